// File: doc/BRIEF.md
# Virtual Running Priority Tracker

This block follows which virtual interrupts are currently being handled on a virtual CPU interface and reports the running priority through a 32-bit read-only register. An activation event carries the ID of an interrupt that has just been acknowledged, together with its 8-bit priority. A priority-drop event takes away the running status of the newest activation that still holds it. A deactivation event removes the entry with the given ID.

The reported value is the group priority, not the raw priority. The group priority is what remains of the priority when the binary point sits at its lowest legal setting for the implemented number of priority bits. Lower numbers are more urgent. When nothing is active, or when every active entry has had its priority dropped, the register reads as the idle value 0xFF. The idle value is the same for every setting of the priority-bit parameter, so a read cannot reveal how many bits are implemented.

Up to eight activations are held in a stack. A read is requested with a one-cycle strobe, and the answer is registered.

Top module: `vrp_tracker`

## Requirements
- R1: Bits [31:8] of `rd_data` are always zero.
- R2: A read strobe in cycle N makes `rd_valid` high in cycle N+1, and `rd_valid` is low after a cycle without a strobe. The returned value reflects the stack as it stood before the events presented in cycle N.
- R3: An entry's group priority keeps priority bits [7:8-K] and zeroes the rest, where K is the smaller of `PRIO_BITS` and 7. With `PRIO_BITS`=8 this gives bits [7:1] with bit 0 zero (0x21 reads 0x20, 0x27 reads 0x26). With `PRIO_BITS`=5 it gives bits [7:3] (0x27 reads 0x20).
- R4: With no entry held, a read returns 0xFF.
- R5: When entries are held but all of them have been priority-dropped, a read returns 0xFF. The idle value is 0xFF for every `PRIO_BITS` setting.
- R6: Otherwise a read returns the numerically smallest group priority among the held entries that are still running.
- R7: A drop clears the running flag of the most recently activated entry that is still running. A drop when no entry is running changes nothing.
- R8: A deactivation removes the oldest held entry whose ID matches, whether or not that entry is running. A deactivation with no matching ID changes nothing.
- R9: The stack holds at most `DEPTH` (8) entries. An activation that arrives while the stack is full and no deactivation is presented is ignored. If a deactivation removes an entry in the same cycle, the activation is accepted.
- R10: Events in the same cycle are applied in this order: deactivation, then drop, then activation. A drop therefore never clears an entry pushed in the same cycle, and it acts on the stack after the removal.
- R11: A synchronous active-low reset empties the stack and clears `rd_valid` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | Activation event |
| act_id | input | ID_W | ID of the activated interrupt |
| act_prio | input | 8 | Priority of the activated interrupt |
| drop_valid | input | 1 | Priority-drop event |
| deact_valid | input | 1 | Deactivation event |
| deact_id | input | ID_W | ID of the interrupt to deactivate |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Running priority register value |
| rd_valid | output | 1 | `rd_data` is valid this cycle |

## Verification
Deactivation, priority drop and activation can all be presented in the same cycle, and a read can also coincide with any of them. The bench sets up two running entries and then presents a drop together with a deactivation of the newer entry. If the deactivation is applied first, the drop falls on the older entry and the next read is idle. The bench also presents a drop together with a new activation and expects the new entry to keep running. Each read issued alongside an event is checked against the value from before that event.

// File: rtl/vrp_pkg.sv
// Package: shared types and helpers for the virtual running priority tracker.
// Assumes 8-bit priorities and a 32-bit register view.
package vrp_pkg;

    localparam int PRIO_W = 8;
    localparam int REG_W = 32;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

    // One stack slot: occupancy, running flag, stored group priority
    typedef struct packed {
        logic              vld;
        logic              run;
        logic [PRIO_W-1:0] grp;
    } ent_t;

    // Mask that keeps the group field for the lowest binary point setting
    function automatic logic [PRIO_W-1:0] grp_mask(input int pbits);
        int keep;
        keep = (pbits > 7) ? 7 : pbits;
        return 8'(8'hFF << (PRIO_W - keep));
    endfunction

endpackage

// File: rtl/vrp_grp_fmt.sv
// Module: converts a raw priority to its group priority for the lowest
// binary point the implemented bit count allows.
// Assumes PRIO_BITS in 1..8; unimplemented low bits are discarded.
module vrp_grp_fmt
    import vrp_pkg::*;
#(
    parameter int PRIO_BITS = 8
) (
    input  logic [PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0] grp
);

    localparam logic [PRIO_W-1:0] MASK = grp_mask(PRIO_BITS);

    // Keep only the group field bits
    assign grp = prio & MASK;

endmodule

// File: rtl/vrp_stack.sv
// Module: activation stack. Entries are packed from index 0 (oldest) up
// to held-1 (newest). Each cycle applies removal by ID, then priority drop
// on the newest running entry, then a push when room remains.
// Assumes IDs of held entries are distinct; on duplicates the oldest goes.
module vrp_stack
    import vrp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [ID_W-1:0]         push_id,
    input  logic [PRIO_W-1:0]       push_grp,
    input  logic                    drop,
    input  logic                    rm,
    input  logic [ID_W-1:0]         rm_id,
    output ent_t [DEPTH-1:0]        ents,
    output logic [CNT_W-1:0]        held
);

    ent_t [DEPTH-1:0]           ent_q;
    ent_t [DEPTH-1:0]           ent_a;
    ent_t [DEPTH-1:0]           ent_b;
    ent_t [DEPTH-1:0]           ent_d;
    ent_t [DEPTH:0]             ent_ext;
    logic [DEPTH-1:0][ID_W-1:0] id_q;
    logic [DEPTH-1:0][ID_W-1:0] id_a;
    logic [DEPTH-1:0][ID_W-1:0] id_d;
    logic [DEPTH:0][ID_W-1:0]   id_ext;
    logic [CNT_W-1:0]           held_q;
    logic [CNT_W-1:0]           held_a;
    logic [CNT_W-1:0]           held_d;
    logic                       hit;
    logic [CNT_W-1:0]           hit_idx;
    logic                       dropped;
    logic                       room;

    // Locate the oldest entry matching the deactivation ID
    always_comb begin
        hit = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rm && !hit && ent_q[i].vld && (id_q[i] == rm_id)) begin
                hit = 1'b1;
                hit_idx = CNT_W'(i);
            end
        end
    end

    // Extend the arrays by one empty slot so a shift never reads past the end
    assign ent_ext = {ent_t'('0), ent_q};
    assign id_ext  = {{ID_W{1'b0}}, id_q};

    // Close the gap left by a removed entry
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (hit && (CNT_W'(i) >= hit_idx)) begin
                ent_a[i] = ent_ext[i+1];
                id_a[i]  = id_ext[i+1];
            end else begin
                ent_a[i] = ent_q[i];
                id_a[i]  = id_q[i];
            end
        end
        held_a = held_q - CNT_W'(hit);
    end

    // Clear the running flag of the newest still-running entry
    always_comb begin
        ent_b = ent_a;
        dropped = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (drop && !dropped && ent_a[i].vld && ent_a[i].run) begin
                ent_b[i].run = 1'b0;
                dropped = 1'b1;
            end
        end
    end

    // Push a new running entry on top when a slot is free
    always_comb begin
        ent_d = ent_b;
        id_d = id_a;
        room = (held_a < CNT_W'(DEPTH));
        held_d = held_a;
        for (int i = 0; i < DEPTH; i++) begin
            if (push && room && (held_a == CNT_W'(i))) begin
                ent_d[i].vld = 1'b1;
                ent_d[i].run = 1'b1;
                ent_d[i].grp = push_grp;
                id_d[i] = push_id;
            end
        end
        if (push && room) begin
            held_d = held_a + CNT_W'(1);
        end
    end

    // Stack state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q  <= '0;
            id_q   <= '0;
            held_q <= '0;
        end else begin
            ent_q  <= ent_d;
            id_q   <= id_d;
            held_q <= held_d;
        end
    end

    assign ents = ent_q;
    assign held = held_q;

endmodule

// File: rtl/vrp_min_sel.sv
// Module: picks the smallest group priority among held, running entries.
// Assumes a stored group priority never exceeds 0xFE.
module vrp_min_sel
    import vrp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  ent_t [DEPTH-1:0]  ents,
    output logic              any_run,
    output logic [PRIO_W-1:0] min_grp
);

    // Linear minimum search across the running entries
    always_comb begin
        any_run = 1'b0;
        min_grp = IDLE_PRIO;
        for (int i = 0; i < DEPTH; i++) begin
            if (ents[i].vld && ents[i].run) begin
                any_run = 1'b1;
                if (ents[i].grp < min_grp) begin
                    min_grp = ents[i].grp;
                end
            end
        end
    end

endmodule

// File: rtl/vrp_tracker.sv
// Module: top of the virtual running priority tracker. Converts incoming
// priorities to group form, keeps the activation stack, and answers
// register reads one cycle after the strobe with the pre-event value.
// Assumes at most one of each event type per cycle.
module vrp_tracker
    import vrp_pkg::*;
#(
    parameter int PRIO_BITS = 8,
    parameter int DEPTH = 8,
    parameter int ID_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_valid,
    input  logic [ID_W-1:0]   act_id,
    input  logic [PRIO_W-1:0] act_prio,
    input  logic              drop_valid,
    input  logic              deact_valid,
    input  logic [ID_W-1:0]   deact_id,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    output logic              rd_valid
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PRIO_W-1:0]  act_grp;
    ent_t [DEPTH-1:0]   ents;
    logic [CNT_W-1:0]   held;
    logic               any_run;
    logic [PRIO_W-1:0]  min_grp;
    logic [PRIO_W-1:0]  run_prio;
    logic [REG_W-1:0]   rd_data_q;
    logic               rd_valid_q;

    vrp_grp_fmt #(.PRIO_BITS(PRIO_BITS)) u_fmt (
        .prio (act_prio),
        .grp  (act_grp)
    );

    vrp_stack #(.DEPTH(DEPTH), .ID_W(ID_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (act_valid),
        .push_id  (act_id),
        .push_grp (act_grp),
        .drop     (drop_valid),
        .rm       (deact_valid),
        .rm_id    (deact_id),
        .ents     (ents),
        .held     (held)
    );

    vrp_min_sel #(.DEPTH(DEPTH)) u_min (
        .ents    (ents),
        .any_run (any_run),
        .min_grp (min_grp)
    );

    // Idle when nothing runs, otherwise the best group priority
    assign run_prio = any_run ? min_grp : IDLE_PRIO;

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) begin
                rd_data_q <= {{(REG_W-PRIO_W){1'b0}}, run_prio};
            end
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/vrp_tracker_chk.sv
// Module: property checker for the tracker, attached through bind.
// Assumes it observes the top-level ports and the stack occupancy.
module vrp_tracker_chk
    import vrp_pkg::*;
#(
    parameter int PRIO_BITS = 8,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act_valid,
    input logic             deact_valid,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [REG_W-1:0] rd_data,
    input logic [CNT_W-1:0] held
);

    localparam logic [PRIO_W-1:0] GMASK = grp_mask(PRIO_BITS);

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[31:8] == 24'd0)); // R1
    AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R2
    AST_GRP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_data[7:0] != IDLE_PRIO)) |-> ((rd_data[7:0] & ~GMASK) == 8'd0)); // R3
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (held == '0)) |=> (rd_data[7:0] == IDLE_PRIO)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        held <= CNT_W'(DEPTH)); // R9
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((held == CNT_W'(DEPTH)) && act_valid && !deact_valid) |=> (held == CNT_W'(DEPTH))); // R9
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> ((held == '0) && !rd_valid)); // R11

endmodule

bind vrp_tracker vrp_tracker_chk #(.PRIO_BITS(PRIO_BITS), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_valid   (act_valid),
    .deact_valid (deact_valid),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .held        (held)
);

// File: tb/vrp_tracker_bench.sv
module vrp_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    typedef struct packed {
        logic       act;
        logic [5:0] id;
        logic [7:0] prio;
        logic       drp;
        logic       dea;
        logic [5:0] did;
        logic       rd;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // act id prio drp dea did rd exp req
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'hFF, 4'd4},  // R4 empty
        '{1'b1, 6'd1, 8'h40, 1'b0, 1'b0, 6'd0, 1'b1, 8'hFF, 4'd2},  // R2 pre-event value
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'h40, 4'd6},  // R6
        '{1'b1, 6'd2, 8'h21, 1'b0, 1'b0, 6'd0, 1'b1, 8'h40, 4'd2},  // R2
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'h20, 4'd3},  // R3 0x21->0x20
        '{1'b1, 6'd3, 8'h80, 1'b0, 1'b0, 6'd0, 1'b1, 8'h20, 4'd6},  // R6
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'h20, 4'd6},  // R6 min kept
        '{1'b0, 6'd0, 8'h00, 1'b1, 1'b0, 6'd0, 1'b1, 8'h20, 4'd2},  // drop id3
        '{1'b0, 6'd0, 8'h00, 1'b1, 1'b0, 6'd0, 1'b1, 8'h20, 4'd7},  // drop id2
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'h40, 4'd7},  // R7
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b1, 6'd2, 1'b1, 8'h40, 4'd8},  // R8 remove dropped
        '{1'b0, 6'd0, 8'h00, 1'b1, 1'b0, 6'd0, 1'b1, 8'h40, 4'd7},  // R7 skips dropped id3
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'hFF, 4'd5},  // R5
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b1, 6'd1, 1'b1, 8'hFF, 4'd5},  // R5
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b1, 6'd3, 1'b0, 8'h00, 4'd2},  // R2 no strobe
        '{1'b1, 6'd4, 8'h10, 1'b0, 1'b0, 6'd0, 1'b1, 8'hFF, 4'd4},  // R4
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b1, 6'd7, 1'b1, 8'h10, 4'd6},  // no-match deact
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'h10, 4'd8},  // R8 no match
        '{1'b1, 6'd5, 8'h30, 1'b1, 1'b0, 6'd0, 1'b1, 8'h10, 4'd10}, // drop + push
        '{1'b1, 6'd6, 8'h50, 1'b0, 1'b0, 6'd0, 1'b1, 8'h30, 4'd10}, // R10 new entry runs
        '{1'b0, 6'd0, 8'h00, 1'b1, 1'b1, 6'd6, 1'b1, 8'h30, 4'd10}, // deact + drop
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'hFF, 4'd10}, // R10 deact first
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b1, 6'd4, 1'b0, 8'h00, 4'd2},  // R2
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b1, 6'd5, 1'b1, 8'hFF, 4'd5},  // R5
        '{1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1, 8'hFF, 4'd4}   // R4
    };

    logic        clk;
    logic        rst_n;
    logic        act_valid;
    logic [5:0]  act_id;
    logic [7:0]  act_prio;
    logic        drop_valid;
    logic        deact_valid;
    logic [5:0]  deact_id;
    logic        rd_en;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [31:0] rd_data_p5;
    logic        rd_valid_p5;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    vrp_tracker u_vrp_tracker (
        .clk (clk), .rst_n (rst_n), .act_valid (act_valid), .act_id (act_id),
        .act_prio (act_prio), .drop_valid (drop_valid), .deact_valid (deact_valid),
        .deact_id (deact_id), .rd_en (rd_en), .rd_data (rd_data), .rd_valid (rd_valid)
    );

    vrp_tracker #(.PRIO_BITS(5)) u_vrp_tracker_p5 (
        .clk (clk), .rst_n (rst_n), .act_valid (act_valid), .act_id (act_id),
        .act_prio (act_prio), .drop_valid (drop_valid), .deact_valid (deact_valid),
        .deact_id (deact_id), .rd_en (rd_en), .rd_data (rd_data_p5), .rd_valid (rd_valid_p5)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Present one cycle of stimulus, return at the following falling edge
    task automatic cyc(input logic a, input logic [5:0] id, input logic [7:0] pr,
                       input logic d, input logic x, input logic [5:0] xid, input logic r);
        act_valid = a; act_id = id; act_prio = pr;
        drop_valid = d; deact_valid = x; deact_id = xid; rd_en = r;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        act_valid = 1'b0; act_id = '0; act_prio = '0;
        drop_valid = 1'b0; deact_valid = 1'b0; deact_id = '0; rd_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R11: reset holds the read side quiet
        check("R11", {31'd0, rd_valid}, 32'd0);
        check("R11", rd_data, 32'd0);
        rst_n = 1'b1;

        // Table walk
        for (int k = 0; k < NV; k++) begin
            cyc(VECS[k].act, VECS[k].id, VECS[k].prio, VECS[k].drp,
                VECS[k].dea, VECS[k].did, VECS[k].rd);
            if (VECS[k].rd) begin
                check("R2", {31'd0, rd_valid}, 32'd1);
                check("R1", {8'd0, rd_data[31:8]}, 32'd0);
                check(req_name(VECS[k].req), {24'd0, rd_data[7:0]}, {24'd0, VECS[k].exp});
            end else begin
                check("R2", {31'd0, rd_valid}, 32'd0);
            end
        end

        // R9: fill the stack, then overflow push is ignored
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, 6'(10 + i), 8'h70, 1'b0, 1'b0, 6'd0, 1'b0);
        end
        cyc(1'b1, 6'd30, 8'h02, 1'b0, 1'b0, 6'd0, 1'b0);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1);
        check("R9", rd_data, 32'h70);
        // R9: a removal in the same cycle makes room
        cyc(1'b1, 6'd31, 8'h04, 1'b0, 1'b1, 6'd10, 1'b0);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1);
        check("R9", rd_data, 32'h04);

        // R11: reset with a full stack empties it
        rst_n = 1'b0;
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1);
        check("R11", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1);
        check("R11", rd_data, 32'hFF);

        // R3: group field depends on implemented bits
        cyc(1'b1, 6'd1, 8'h27, 1'b0, 1'b0, 6'd0, 1'b0);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1);
        check("R3", rd_data, 32'h26);
        check("R3", rd_data_p5, 32'h20);
        // R5: idle is 0xFF whatever the bit count
        cyc(1'b0, 6'd0, 8'h00, 1'b1, 1'b0, 6'd0, 1'b0);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1);
        check("R5", rd_data, 32'hFF);
        check("R5", rd_data_p5, 32'hFF);
        // R7: drop with nothing running has no effect; new push still runs
        cyc(1'b0, 6'd0, 8'h00, 1'b1, 1'b0, 6'd0, 1'b0);
        cyc(1'b1, 6'd2, 8'h08, 1'b0, 1'b0, 6'd0, 1'b0);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b1);
        check("R7", rd_data, 32'h08);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 6'd0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule